// File: doc/BRIEF.md
# Dynamic On-Die Termination Select Controller

This block decides which termination a DRAM data pin presents, cycle by cycle. Outside writes it applies the nominal termination while the termination-enable pin is high. Around each write burst it swaps to a write-specific termination for a fixed window and then swaps back. No mode-register write is needed for the swap. The block produces only a two-bit termination code; the resistor network and its calibration sit downstream.

A write command opens a write-termination episode when the two-bit write-termination field selects a value and write leveling is off. The write code appears a fixed number of cycles after the command. It is withdrawn a burst-length-dependent number of cycles after the command. A further write that arrives while an episode is open moves the end of the window later; the start is not repeated. Every write also arms a hold timer that keeps the nominal termination on after the pin falls.

The write sequencer is a three-state machine. `SEQ_IDLE` goes to `SEQ_LEAD` on an accepted write, or straight to `SEQ_WRITE` when the start latency is zero. `SEQ_LEAD` goes to `SEQ_WRITE` when the start latency expires. `SEQ_LEAD` or `SEQ_WRITE` goes back to `SEQ_IDLE` when the end count runs out and no accepted write arrives in that cycle.

Top module: `dyn_odt_ctrl`

## Requirements
- R1: After reset the sequencer is idle and the hold timer is clear. With the pin low, `term_code` is 0 (off).
- R2: `wr_term_sel` encodings are 00 = off, 01 = write value A, 10 = write value B and 11 = reserved, treated as off. During the write window the code is 2 for A and 3 for B. With 00 or 11, a write never produces code 2 or 3.
- R3: If a write is accepted at clock edge n, the write code is shown after edges n+LAT_ON through n+LAT_OFF-1. The code is never shown after edge n itself when LAT_ON > 0.
- R4: LAT_OFF is LAT_OFF8 when `wr_bl8` is 1 at the command, and LAT_OFF4 when it is 0.
- R5: A write accepted while an episode is open does not restart the start latency. It moves the end to the later of the current end and its own n+LAT_OFF.
- R6: Outside the write code, `term_code` is 1 (nominal) when `nom_term` is nonzero and either `odt_pin` is high or fewer than HOLD cycles have passed since a write. HOLD is HOLD8 when `wr_bl8` is 1 at that write and HOLD4 when it is 0, and the later end wins.
- R7: With `nom_term` = 0, the code is never 1, so the pin is off (High-Z) outside the write window. The write code still appears as in R3.
- R8: While `wl_mode` is 1, no write code is shown and writes open no episode. The nominal behaviour of R6 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_term_sel | input | 2 | Write-termination field (00 off, 01 A, 10 B, 11 reserved) |
| nom_term | input | 3 | Nominal termination setting, 0 = disabled |
| odt_pin | input | 1 | Termination-enable pin |
| wr_cmd | input | 1 | One-cycle write command strobe |
| wr_bl8 | input | 1 | Burst length of this write: 1 = eight beats, 0 = four |
| wl_mode | input | 1 | Write-leveling mode flag |
| term_code | output | 2 | 0 off, 1 nominal, 2 write A, 3 write B |

## Verification
The output is combinational from registered state, so a write sampled at edge n first shows its write code after edge n+LAT_ON. It is withdrawn after edge n+LAT_OFF4 or n+LAT_OFF8, and its hold ends after edge n+HOLD4 or n+HOLD8. The pin, the field and the write-leveling flag act in the same cycle. The bench model counts edges with integers and keeps the episode start, the episode end and the hold end as absolute cycle numbers. After each falling edge it drives the inputs, waits a little, and compares the code with the model. Every cycle is therefore checked, including the cycle on each side of every window edge.

// File: rtl/dyn_odt_pkg.sv
package dyn_odt_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LEAD  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        TC_OFF  = 2'd0,
        TC_NOM  = 2'd1,
        TC_WR_A = 2'd2,
        TC_WR_B = 2'd3
    } term_code_t;

    function automatic logic sel_enables(input logic [1:0] sel);
        return (sel == 2'b01) || (sel == 2'b10);
    endfunction

endpackage

// File: rtl/odt_write_seq.sv
module odt_write_seq
    import dyn_odt_pkg::*;
#(
    parameter int LAT_ON   = 2,
    parameter int LAT_OFF4 = 6,
    parameter int LAT_OFF8 = 8,
    parameter int CW       = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic bl8,
    output logic wr_window,
    output logic idle
);
    localparam logic [CW-1:0] ON_C   = CW'(LAT_ON);
    localparam logic [CW-1:0] OFF4_C = CW'(LAT_OFF4);
    localparam logic [CW-1:0] OFF8_C = CW'(LAT_OFF8);
    localparam logic [CW-1:0] ONE_C  = CW'(1);

    seq_state_t    state, state_nx;
    logic [CW-1:0] lead_cnt, end_cnt;
    logic [CW-1:0] end_dec, end_new, end_ext;

    assign end_dec = (end_cnt == '0) ? '0 : end_cnt - ONE_C;
    assign end_new = bl8 ? OFF8_C : OFF4_C;
    assign end_ext = (end_dec > end_new) ? end_dec : end_new;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE: begin
                if (start) state_nx = (LAT_ON == 0) ? SEQ_WRITE : SEQ_LEAD;
            end
            SEQ_LEAD: begin
                if (lead_cnt <= ONE_C) state_nx = SEQ_WRITE;
                if (!start && end_cnt <= ONE_C) state_nx = SEQ_IDLE;
            end
            SEQ_WRITE: begin
                if (!start && end_cnt <= ONE_C) state_nx = SEQ_IDLE;
            end
            default: state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lead_cnt <= '0;
            end_cnt  <= '0;
        end else if (state == SEQ_IDLE) begin
            lead_cnt <= start ? ON_C : '0;
            end_cnt  <= start ? end_new : '0;
        end else begin
            lead_cnt <= (lead_cnt == '0) ? '0 : lead_cnt - ONE_C;
            end_cnt  <= start ? end_ext : end_dec;
        end
    end

    always_comb begin
        wr_window = (state == SEQ_WRITE);
        idle      = (state == SEQ_IDLE);
    end

endmodule

// File: rtl/odt_hold_timer.sv
module odt_hold_timer #(
    parameter int HOLD4 = 4,
    parameter int HOLD8 = 6,
    parameter int CW    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_cmd,
    input  logic bl8,
    output logic hold_active
);
    localparam logic [CW-1:0] H4_C  = CW'(HOLD4);
    localparam logic [CW-1:0] H8_C  = CW'(HOLD8);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    logic [CW-1:0] hold_cnt, hold_dec, hold_new;

    assign hold_dec = (hold_cnt == '0) ? '0 : hold_cnt - ONE_C;
    assign hold_new = bl8 ? H8_C : H4_C;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_cnt <= '0;
        else if (wr_cmd) hold_cnt <= (hold_dec > hold_new) ? hold_dec : hold_new;
        else             hold_cnt <= hold_dec;
    end

    assign hold_active = (hold_cnt != '0);

endmodule

// File: rtl/odt_term_mux.sv
module odt_term_mux
    import dyn_odt_pkg::*;
(
    input  logic       wr_window,
    input  logic [1:0] wr_term_sel,
    input  logic       wl_mode,
    input  logic       nom_on,
    input  logic       odt_pin,
    input  logic       hold_active,
    output term_code_t code
);
    always_comb begin
        if (wr_window && !wl_mode && wr_term_sel == 2'b01)
            code = TC_WR_A;
        else if (wr_window && !wl_mode && wr_term_sel == 2'b10)
            code = TC_WR_B;
        else if (nom_on && (odt_pin || hold_active))
            code = TC_NOM;
        else
            code = TC_OFF;
    end

endmodule

// File: rtl/dyn_odt_ctrl.sv
module dyn_odt_ctrl
    import dyn_odt_pkg::*;
#(
    parameter int LAT_ON   = 2,
    parameter int LAT_OFF4 = 6,
    parameter int LAT_OFF8 = 8,
    parameter int HOLD4    = 4,
    parameter int HOLD8    = 6,
    parameter int NOM_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       wr_term_sel,
    input  logic [NOM_W-1:0] nom_term,
    input  logic             odt_pin,
    input  logic             wr_cmd,
    input  logic             wr_bl8,
    input  logic             wl_mode,
    output logic [1:0]       term_code
);
    localparam int LAT_MAX = (LAT_OFF8 > LAT_OFF4) ? LAT_OFF8 : LAT_OFF4;
    localparam int HLD_MAX = (HOLD8 > HOLD4) ? HOLD8 : HOLD4;
    localparam int ALL_MAX = (LAT_MAX > HLD_MAX) ? LAT_MAX : HLD_MAX;
    localparam int CW      = $clog2(ALL_MAX + 2);

    logic       start, wr_window, seq_idle, hold_active;
    term_code_t code;

    assign start = wr_cmd && sel_enables(wr_term_sel) && !wl_mode;

    odt_write_seq #(
        .LAT_ON(LAT_ON), .LAT_OFF4(LAT_OFF4), .LAT_OFF8(LAT_OFF8), .CW(CW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .bl8(wr_bl8),
        .wr_window(wr_window), .idle(seq_idle)
    );

    odt_hold_timer #(
        .HOLD4(HOLD4), .HOLD8(HOLD8), .CW(CW)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .bl8(wr_bl8),
        .hold_active(hold_active)
    );

    odt_term_mux u_mux (
        .wr_window(wr_window), .wr_term_sel(wr_term_sel), .wl_mode(wl_mode),
        .nom_on(nom_term != '0), .odt_pin(odt_pin),
        .hold_active(hold_active), .code(code)
    );

    assign term_code = code;

endmodule

// File: rtl/dyn_odt_ctrl_chk.sv
module dyn_odt_ctrl_chk #(
    parameter int LAT_ON = 2,
    parameter int NOM_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       wr_term_sel,
    input logic [NOM_W-1:0] nom_term,
    input logic             odt_pin,
    input logic             wr_cmd,
    input logic             wl_mode,
    input logic             seq_idle,
    input logic [1:0]       term_code
);
    AST_CODE_A_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        term_code == 2'd2 |-> wr_term_sel == 2'b01); // R2
    AST_CODE_B_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        term_code == 2'd3 |-> wr_term_sel == 2'b10); // R2
    AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (LAT_ON > 0 && wr_cmd && seq_idle) |=> !term_code[1]); // R3
    AST_PIN_GIVES_NOM: assert property (@(posedge clk) disable iff (!rst_n)
        (odt_pin && nom_term != '0 && !term_code[1]) |-> term_code == 2'd1); // R6
    AST_NOM_OFF_NO_NOM: assert property (@(posedge clk) disable iff (!rst_n)
        nom_term == '0 |-> term_code != 2'd1); // R7
    AST_WL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wl_mode |-> !term_code[1]); // R8
endmodule

bind dyn_odt_ctrl dyn_odt_ctrl_chk #(.LAT_ON(LAT_ON), .NOM_W(NOM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_term_sel(wr_term_sel), .nom_term(nom_term),
    .odt_pin(odt_pin), .wr_cmd(wr_cmd), .wl_mode(wl_mode),
    .seq_idle(seq_idle), .term_code(term_code)
);

// File: tb/dyn_odt_ctrl_test.sv
`timescale 1ns/1ps
module dyn_odt_ctrl_test;
    localparam int LAT_ON = 2, LAT_OFF4 = 6, LAT_OFF8 = 8, HOLD4 = 4, HOLD8 = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] wr_term_sel = 2'b00;
    logic [2:0] nom_term = 3'd0;
    logic       odt_pin = 1'b0, wr_cmd = 1'b0, wr_bl8 = 1'b0, wl_mode = 1'b0;
    logic [1:0] term_code;

    int    total = 0, bad = 0;
    bit    done = 0;
    string ph = "R1";

    int  ncyc = 0, ep_first = 0, ep_end = 0, hold_end = 0;
    bit  ep_on = 0;

    always #10 clk = ~clk;

    dyn_odt_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_term_sel(wr_term_sel), .nom_term(nom_term),
        .odt_pin(odt_pin), .wr_cmd(wr_cmd), .wr_bl8(wr_bl8), .wl_mode(wl_mode),
        .term_code(term_code)
    );

    // behavioural reference: absolute cycle numbers for window edges
    always @(posedge clk) begin
        if (!rst_n) begin
            ep_on = 0; ep_first = 0; ep_end = 0; hold_end = 0; ncyc = 0;
        end else begin
            ncyc = ncyc + 1;
            if (wr_cmd) begin
                if (ncyc + (wr_bl8 ? HOLD8 : HOLD4) > hold_end)
                    hold_end = ncyc + (wr_bl8 ? HOLD8 : HOLD4);
                if ((wr_term_sel == 2'b01 || wr_term_sel == 2'b10) && !wl_mode) begin
                    if (!ep_on) begin
                        ep_on = 1; ep_first = ncyc; ep_end = 0;
                    end
                    if (ncyc + (wr_bl8 ? LAT_OFF8 : LAT_OFF4) > ep_end)
                        ep_end = ncyc + (wr_bl8 ? LAT_OFF8 : LAT_OFF4);
                end
            end
            if (ep_on && ncyc >= ep_end) ep_on = 0;
        end
    end

    function automatic int expected();
        bit wr = ep_on && (ncyc - ep_first) >= LAT_ON && !wl_mode;
        if (wr && wr_term_sel == 2'b01) return 2;
        if (wr && wr_term_sel == 2'b10) return 3;
        if (nom_term != 0 && (odt_pin || ncyc < hold_end)) return 1;
        return 0;
    endfunction

    task automatic step();
        #1;
        total++;
        if (int'(term_code) != expected()) begin
            bad++;
            $display("FAIL %s cycle %0d: term_code=%0d expected %0d",
                     ph, ncyc, term_code, expected());
        end
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write(input logic bl8);
        wr_cmd = 1'b1; wr_bl8 = bl8;
        step();
        wr_cmd = 1'b0; wr_bl8 = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: term_code=%0d expected finish", term_code);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        ph = "R1"; step();                 // reset state, pin low
        rst_n = 1'b1;
        steps(2);
        ph = "R6"; nom_term = 3'd3; odt_pin = 1'b1; steps(3);
        odt_pin = 1'b0; steps(2);
        ph = "R3"; odt_pin = 1'b1; wr_term_sel = 2'b01;
        write(1'b0); steps(10);
        ph = "R4"; wr_term_sel = 2'b10;
        write(1'b1); steps(12);
        ph = "R2"; wr_term_sel = 2'b11;
        write(1'b1); steps(10);
        wr_term_sel = 2'b00;
        write(1'b0); steps(8);
        ph = "R5"; wr_term_sel = 2'b01;
        write(1'b0); steps(2); write(1'b0); steps(3); write(1'b1); steps(14);
        write(1'b0); steps(5); write(1'b0); steps(10);   // extend right at the end
        ph = "R6"; odt_pin = 1'b0;
        write(1'b1); steps(2); write(1'b0); steps(10);
        write(1'b0); steps(8);
        ph = "R7"; nom_term = 3'd0; wr_term_sel = 2'b10;
        write(1'b0); steps(8);
        odt_pin = 1'b1; write(1'b1); steps(10);
        ph = "R8"; nom_term = 3'd5; wl_mode = 1'b1; wr_term_sel = 2'b01;
        write(1'b1); steps(10);
        wl_mode = 1'b0; write(1'b1); steps(3);
        wl_mode = 1'b1; steps(2); wl_mode = 1'b0; steps(8);
        ph = "R1"; rst_n = 1'b0; odt_pin = 1'b0; write(1'b0); steps(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule